// File: doc/BRIEF.md
# Key Matrix Scan Responder

This block stands in for a passive keyboard matrix that a scanning controller reads. The controller drives a set of strobe (column) lines and reads back a set of sense (row) lines. A sense line is high while at least one pressed key in its row sits on a strobe line that is currently driven. The sense outputs are combinational from the strobe inputs and the stored key state, so a strobe change shows on the sense outputs in the same cycle.

Key events arrive as 8-bit codes. Bit 7 selects release (1) or press (0), and the low seven bits index a loadable 128-entry position table. Accepted events wait in a 16-entry FIFO. One queued event is taken out per tick, so events reach the matrix at a fixed rate. The tick comes every `TICK_CYCLES` clocks, which by default is 1/32 s at 125 MHz. Positions in the reserved eighth row do not touch the matrix. They drive a small set of discrete side-button outputs, each with its own polarity-inversion input. A restore pulse releases every matrix key, empties the queue and clears the overflow flag.

Top module: `keymatrix_responder`

## Requirements
- R1: `sense_o[r]` is 1 exactly when row r holds a pressed key whose column strobe bit in `strobe_i` is 1. It follows strobe changes in the same cycle, and it is 0 whenever `strobe_i` is zero.
- R2: A position-table entry is laid out as {valid bit 7, row bits 6:4, column bits 3:0}. The table is written through `map_we_i`/`map_addr_i`/`map_data_i`. An event whose entry has bit 7 clear is discarded with no visible effect. Columns at or above the strobe count are ignored.
- R3: The event code bit 7 = 1 releases the key (clears its bit) and bit 7 = 0 presses it (sets its bit). The table is indexed by code bits 6:0 only.
- R4: An entry whose row field is 7 drives side output number "column" (0 to 4) to (press XOR `side_invert_i[column]`). After reset, `side_o` equals `side_invert_i`.
- R5: Events are applied in arrival order, at most one per tick, with ticks `TICK_CYCLES` clocks apart. The FIFO holds 16 events.
- R6: An event offered while the FIFO holds 16 entries, and none leaves in that cycle, is dropped. `overflow_o` then goes to 1 and stays at 1 until reset or restore.
- R7: A cycle with `restore_i` = 1 releases all matrix keys, empties the FIFO, clears `overflow_o` and discards any event offered in that cycle.
- R8: After reset, `sense_o` is 0, `overflow_o` is 0, every table entry is invalid and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 11 | Strobe (column) lines driven by the scanner |
| sense_o | output | 7 | Sense (row) lines read by the scanner |
| side_invert_i | input | 5 | Per-line polarity inversion for the side outputs |
| side_o | output | 5 | Discrete side-button levels |
| ev_valid_i | input | 1 | Key event offered this cycle |
| ev_code_i | input | 8 | Key event code: bit 7 release, bits 6:0 table index |
| map_we_i | input | 1 | Position-table write enable |
| map_addr_i | input | 7 | Position-table write address |
| map_data_i | input | 8 | Position-table write data |
| restore_i | input | 1 | Release all keys and flush the queue |
| overflow_o | output | 1 | Sticky: an event was dropped on a full queue |

## Verification
The hardest state to reach is a full queue. Events drain one per tick, so a slow trickle never fills it. The bench therefore holds the event valid for many consecutive cycles with a short tick period, which offers far more events than the few ticks in that window can remove. It then restores and waits several ticks to show that none of the pending presses ever lands. The rate limit needs the exact tick phase, and the ports do not show it. The bench finds that phase by polling for the first applied event and then counts a full period forward to the second.

// File: rtl/keymatrix_responder.sv
module keymatrix_responder #(
  parameter int STROBES     = 11,
  parameter int SENSES      = 7,
  parameter int SIDES       = 5,
  parameter int DEPTH       = 16,
  parameter int TICK_CYCLES = 3906250
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STROBES-1:0] strobe_i,
  output logic [SENSES-1:0]  sense_o,
  input  logic [SIDES-1:0]   side_invert_i,
  output logic [SIDES-1:0]   side_o,
  input  logic               ev_valid_i,
  input  logic [7:0]         ev_code_i,
  input  logic               map_we_i,
  input  logic [6:0]         map_addr_i,
  input  logic [7:0]         map_data_i,
  input  logic               restore_i,
  output logic               overflow_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(TICK_CYCLES + 1);
  localparam logic [2:0] SIDE_ROW = 3'd7;

  logic [STROBES-1:0] keys_q [SENSES];
  logic [SIDES-1:0]   side_q;
  logic [7:0]         map_q  [128];
  logic [7:0]         fifo_q [DEPTH];
  logic [AW-1:0]      wr_q, rd_q;
  logic [CW-1:0]      cnt_q;
  logic [TW-1:0]      tick_q;
  logic               ovf_q;

  wire tick  = (tick_q == TW'(TICK_CYCLES - 1));
  wire full  = (cnt_q == CW'(DEPTH));
  wire pop   = tick && (cnt_q != '0) && !restore_i;
  wire push  = ev_valid_i && !restore_i && (!full || pop);

  wire [7:0] head  = fifo_q[rd_q];
  wire [7:0] entry = map_q[head[6:0]];
  wire       hit   = pop && entry[7];
  wire [2:0] row   = entry[6:4];
  wire [3:0] col   = entry[3:0];
  wire       press = ~head[7];

  genvar g;
  generate
    for (g = 0; g < SENSES; g++) begin : g_sense
      assign sense_o[g] = |(keys_q[g] & strobe_i);
    end
  endgenerate

  assign side_o     = side_q ^ side_invert_i;
  assign overflow_o = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick ? '0 : tick_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) map_q[i] <= '0;
    end else if (map_we_i) begin
      map_q[map_addr_i] <= map_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (push) fifo_q[wr_q] <= ev_code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (restore_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
      if (ev_valid_i && !push) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < SENSES; r++) keys_q[r] <= '0;
    end else if (restore_i) begin
      for (int r = 0; r < SENSES; r++) keys_q[r] <= '0;
    end else if (hit && row != SIDE_ROW) begin
      for (int r = 0; r < SENSES; r++)
        for (int c = 0; c < STROBES; c++)
          if (3'(r) == row && 4'(c) == col) keys_q[r][c] <= press;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      side_q <= '0;
    end else if (hit && row == SIDE_ROW) begin
      for (int s = 0; s < SIDES; s++)
        if (4'(s) == col) side_q[s] <= press;
    end
  end

  a_r1_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i == '0) |-> (sense_o == '0));

  a_r5_no_drain_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restore_i) |=> (cnt_q >= $past(cnt_q)));

  a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  a_r6_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !restore_i) |=> overflow_o);

  a_r7_restore_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> (cnt_q == '0 && sense_o == '0 && !overflow_o));
endmodule

// File: tb/keymatrix_responder_tb.sv
module keymatrix_responder_tb;
  localparam int TICK = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] strobe = '0;
  logic [6:0]  sense;
  logic [4:0]  side_inv = 5'b01000;
  logic [4:0]  side;
  logic        ev_valid = 1'b0;
  logic [7:0]  ev_code = '0;
  logic        map_we = 1'b0;
  logic [6:0]  map_addr = '0;
  logic [7:0]  map_data = '0;
  logic        restore = 1'b0;
  logic        overflow;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  keymatrix_responder #(.TICK_CYCLES(TICK)) u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .sense_o(sense),
    .side_invert_i(side_inv), .side_o(side), .ev_valid_i(ev_valid),
    .ev_code_i(ev_code), .map_we_i(map_we), .map_addr_i(map_addr),
    .map_data_i(map_data), .restore_i(restore), .overflow_o(overflow));

  // {code, strobe, expected sense}
  localparam logic [25:0] VEC [9] = '{
    {8'h10, 11'h001, 7'h01},  // R1 R3 press row0 col0
    {8'h13, 11'h021, 7'h05},  // R1 press row2 col5
    {8'h12, 11'h400, 7'h40},  // R1 row6 col10
    {8'h30, 11'h7FF, 7'h45},  // R2 unmapped code
    {8'h90, 11'h7FF, 7'h44},  // R3 release via bit7
    {8'h93, 11'h7FF, 7'h40},  // R3
    {8'h92, 11'h7FF, 7'h00},  // R3
    {8'h11, 11'h7FE, 7'h00},  // R1 strobe inactive on col0
    {8'hB0, 11'h001, 7'h02}   // R2 unmapped release
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_map(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); map_we = 1'b1; map_addr = a; map_data = d;
    @(negedge clk); map_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk); ev_valid = 1'b1; ev_code = c;
    @(negedge clk); ev_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (2 * TICK + 2) @(negedge clk);
  endtask

  task automatic do_restore();
    @(negedge clk); restore = 1'b1;
    @(negedge clk); restore = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog expired actual 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    strobe = 11'h7FF;
    @(negedge clk);
    check("R8 reset sense", 32'(sense), 32'h0);
    check("R8 reset overflow", 32'(overflow), 32'h0);
    check("R4 reset side equals invert", 32'(side), 32'h08);
    send(8'h10);
    settle();
    check("R8 table invalid after reset", 32'(sense), 32'h0);

    load_map(7'h10, 8'h80);
    load_map(7'h11, 8'h90);
    load_map(7'h12, 8'hEA);
    load_map(7'h13, 8'hA5);
    load_map(7'h14, 8'h8C);
    load_map(7'h20, 8'hF0);
    load_map(7'h21, 8'hF3);
    do_restore();

    for (int i = 0; i < 9; i++) begin
      send(VEC[i][25:18]);
      settle();
      strobe = VEC[i][17:7];
      @(negedge clk);
      check($sformatf("R1 vector %0d", i), 32'(sense), 32'(VEC[i][6:0]));
    end

    do_restore();
    strobe = 11'h7FF;
    send(8'h14);
    settle();
    check("R2 column beyond strobes ignored", 32'(sense), 32'h0);

    send(8'h20);
    settle();
    check("R4 side0 press", 32'(side), 32'h09);
    send(8'h21);
    settle();
    check("R4 side3 press inverted", 32'(side), 32'h01);
    send(8'hA1);
    settle();
    check("R4 side3 release inverted", 32'(side), 32'h09);
    check("R4 matrix untouched by side row", 32'(sense), 32'h0);

    @(negedge clk); ev_valid = 1'b1; ev_code = 8'h10;
    @(negedge clk); ev_code = 8'h11;
    @(negedge clk); ev_valid = 1'b0;
    begin
      int waited = 0;
      while (sense[0] !== 1'b1 && waited < 3 * TICK) begin
        @(negedge clk); waited++;
      end
      check("R5 first event applied", 32'(sense[0]), 32'h1);
      check("R5 second not in same tick", 32'(sense[1]), 32'h0);
      repeat (TICK - 1) @(negedge clk);
      check("R5 second waits a full period", 32'(sense[1]), 32'h0);
      @(negedge clk);
      check("R5 second applied next tick", 32'(sense[1]), 32'h1);
    end

    do_restore();
    check("R7 restore releases keys", 32'(sense), 32'h0);
    strobe = 11'h001;
    @(negedge clk); ev_valid = 1'b1; ev_code = 8'h10;
    repeat (24) @(negedge clk);
    ev_valid = 1'b0;
    check("R6 overflow set on full queue", 32'(overflow), 32'h1);
    repeat (TICK) @(negedge clk);
    check("R6 overflow sticky", 32'(overflow), 32'h1);
    do_restore();
    check("R7 restore clears overflow", 32'(overflow), 32'h0);
    repeat (3 * TICK) @(negedge clk);
    check("R7 queue flushed by restore", 32'(sense), 32'h0);
    check("R4 side kept across restore", 32'(side), 32'h09);

    finish_run();
  end
endmodule